// File: doc/BRIEF.md
# Serial-in latched output driver

This block is a cycle-based model of an eight-stage serial-to-parallel register that feeds a bank of output switches through a level-sensitive holding latch. A fast system clock samples four slow external control lines: a serial clock, a serial data line, a strobe and a blanking input. The lines pass through two-flop synchronizers first. Each low-to-high transition of the serial clock pushes one data bit into stage 1 and moves the older bits one stage onward. The last stage drives a serial output, so several blocks can be chained.

While the strobe is high the latch copies the register. While it is low the latch keeps its last value. A high blanking input turns every output off and leaves the register and latch untouched. A timing monitor measures the synchronized lines in system-clock cycles. It sets sticky flags when it sees a setup, hold, clock-width, clock-to-strobe or strobe-width violation. The flags stay set until the clear input is pulsed.

None of the interfaces carries a stream. Every input is a sampled level, so there is no valid/ready handshake and no back-pressure. The outputs are plain levels.

Top module: `shift_latch_driver`

## Requirements
- R1: On each rising edge of the synchronized serial clock, the synchronized serial data enters stage 1 (drive_out[0] when the latch is transparent), and each stage k takes the old value of stage k-1.
- R2: ser_out always carries stage 8, the last stage of the shift register.
- R3: While the strobe is high, the latch equals the shift register, and with blanking low drive_out equals the register contents.
- R4: While the strobe is low, the latch holds its value and drive_out does not change when new bits are shifted in.
- R5: While blank_in is high, drive_out is all zeros. An output bit of 1 means that switch is on.
- R6: Blanking alters neither the shift register nor the latch. When blank_in falls, drive_out shows the latch contents again and ser_out is unchanged.
- R7: viol_flags[0] (setup) is set when the serial clock rises fewer than SETUP_CYC cycles after the last data change.
- R8: viol_flags[1] (hold) is set when the data changes fewer than HOLD_CYC cycles after a serial clock rise.
- R9: viol_flags[2] (clock width) is set when a serial clock high phase lasts fewer than CLKW_CYC cycles.
- R10: viol_flags[3] (clock to strobe) is set when the strobe rises fewer than C2S_CYC cycles after a serial clock rise.
- R11: viol_flags[4] (strobe width) is set when a strobe high phase lasts fewer than STBW_CYC cycles.
- R12: Violation flags are sticky until viol_clr is high at a clock edge, which clears them. If a new violation is detected in the same cycle, the new flag is still set.
- R13: Synchronous active-high reset clears the shift register, the latch and the flags, so drive_out and ser_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | External serial clock, asynchronous |
| sdata_in | input | 1 | External serial data, asynchronous |
| strobe_in | input | 1 | Latch transparency level, asynchronous |
| blank_in | input | 1 | High forces all outputs off, asynchronous |
| viol_clr | input | 1 | Clears the sticky violation flags |
| ser_out | output | 1 | Last shift stage, for chaining |
| drive_out | output | W | Output switch states, bit 0 is stage 1 |
| viol_flags | output | 5 | Sticky flags: setup, hold, clock width, clock to strobe, strobe width |

## Verification
The shift path is driven in four settings. With the strobe held high, outputs must follow every shift, which separates a transparent latch from an edge-loaded one. With the strobe low during loading, outputs must stay frozen until a later strobe pulse. With blanking high during loading and strobing, the bench checks that blanking only masks the outputs and does not clear state. Random words with random blanking levels are shifted under legal timing, and the bench requires all flags to stay clear. Five directed sequences each break exactly one timing rule, and the bench checks that only the matching flag is set, that it stays set, and that it clears on viol_clr.

// File: rtl/sld_pkg.sv
package sld_pkg;
  // Index of each sticky violation flag
  localparam int VIOL_SETUP = 0;
  localparam int VIOL_HOLD  = 1;
  localparam int VIOL_CLKW  = 2;
  localparam int VIOL_C2S   = 3;
  localparam int VIOL_STBW  = 4;
  localparam int NUM_VIOL   = 5;
  // Index of each synchronized external line
  localparam int SYNC_SCLK  = 0;
  localparam int SYNC_DATA  = 1;
  localparam int SYNC_STB   = 2;
  localparam int SYNC_BLANK = 3;
  localparam int NUM_SYNC   = 4;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d[i]};
      end
      assign q[i] = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sld_shift_latch.sv
module sld_shift_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         dat_s,
  input  logic         stb_s,
  output logic [W-1:0] shift_q,
  output logic [W-1:0] latch_q
);
  logic         sclk_d;
  logic         step;
  logic [W-1:0] shift_nx;

  always_comb begin
    step     = sclk_s & ~sclk_d;
    shift_nx = step ? {shift_q[W-2:0], dat_s} : shift_q;
  end

  // Latch is transparent while strobe is high: it takes the same value
  // the register takes in this cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      shift_q <= '0;
      latch_q <= '0;
    end else begin
      sclk_d  <= sclk_s;
      shift_q <= shift_nx;
      if (stb_s) latch_q <= shift_nx;
    end
  end
endmodule

// File: rtl/sld_timing_mon.sv
module sld_timing_mon
  import sld_pkg::*;
#(
  parameter int SETUP_CYC = 10,
  parameter int HOLD_CYC  = 10,
  parameter int CLKW_CYC  = 19,
  parameter int C2S_CYC   = 38,
  parameter int STBW_CYC  = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_s,
  input  logic                dat_s,
  input  logic                stb_s,
  input  logic                clr,
  output logic [NUM_VIOL-1:0] flags
);
  localparam int M1   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int M2   = (CLKW_CYC > C2S_CYC) ? CLKW_CYC : C2S_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXV = (M3 > STBW_CYC) ? M3 : STBW_CYC;
  localparam int CW   = $clog2(MAXV + 2);
  localparam logic [CW-1:0] CMAX    = '1;
  localparam logic [CW-1:0] SETUP_L = CW'(SETUP_CYC);
  localparam logic [CW-1:0] HOLD_L  = CW'(HOLD_CYC);
  localparam logic [CW-1:0] CLKW_L  = CW'(CLKW_CYC);
  localparam logic [CW-1:0] C2S_L   = CW'(C2S_CYC);
  localparam logic [CW-1:0] STBW_L  = CW'(STBW_CYC);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + CW'(1);
  endfunction

  logic          sclk_d, dat_d, stb_d;
  logic [CW-1:0] dat_age, since_clk, clk_hi, stb_hi;
  logic          clk_rise, clk_fall, dat_chg, stb_rise, stb_fall;
  logic [CW-1:0] age_nx, since_nx;
  logic [NUM_VIOL-1:0] err;

  always_comb begin
    clk_rise = sclk_s & ~sclk_d;
    clk_fall = ~sclk_s & sclk_d;
    dat_chg  = dat_s ^ dat_d;
    stb_rise = stb_s & ~stb_d;
    stb_fall = ~stb_s & stb_d;
    age_nx   = dat_chg ? '0 : sat_inc(dat_age);
    since_nx = clk_rise ? '0 : sat_inc(since_clk);
    err              = '0;
    err[VIOL_SETUP]  = clk_rise && (age_nx < SETUP_L);
    err[VIOL_HOLD]   = dat_chg && !clk_rise && (since_nx < HOLD_L);
    err[VIOL_CLKW]   = clk_fall && (clk_hi < CLKW_L);
    err[VIOL_C2S]    = stb_rise && (since_nx < C2S_L);
    err[VIOL_STBW]   = stb_fall && (stb_hi < STBW_L);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      dat_d     <= 1'b0;
      stb_d     <= 1'b0;
      dat_age   <= CMAX;
      since_clk <= CMAX;
      clk_hi    <= '0;
      stb_hi    <= '0;
      flags     <= '0;
    end else begin
      sclk_d    <= sclk_s;
      dat_d     <= dat_s;
      stb_d     <= stb_s;
      dat_age   <= age_nx;
      since_clk <= since_nx;
      clk_hi    <= sclk_s ? sat_inc(clk_hi) : '0;
      stb_hi    <= stb_s ? sat_inc(stb_hi) : '0;
      flags     <= (clr ? '0 : flags) | err;
    end
  end
endmodule

// File: rtl/shift_latch_driver.sv
module shift_latch_driver
  import sld_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 10,
  parameter int HOLD_CYC    = 10,
  parameter int CLKW_CYC    = 19,
  parameter int C2S_CYC     = 38,
  parameter int STBW_CYC    = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_in,
  input  logic                sdata_in,
  input  logic                strobe_in,
  input  logic                blank_in,
  input  logic                viol_clr,
  output logic                ser_out,
  output logic [W-1:0]        drive_out,
  output logic [NUM_VIOL-1:0] viol_flags
);
  logic [NUM_SYNC-1:0] raw, synced;
  logic                sclk_s, dat_s, stb_s, blank_s;
  logic [W-1:0]        shift_q, latch_q;

  always_comb begin
    raw             = '0;
    raw[SYNC_SCLK]  = sclk_in;
    raw[SYNC_DATA]  = sdata_in;
    raw[SYNC_STB]   = strobe_in;
    raw[SYNC_BLANK] = blank_in;
  end

  sld_sync #(.N(NUM_SYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  assign sclk_s  = synced[SYNC_SCLK];
  assign dat_s   = synced[SYNC_DATA];
  assign stb_s   = synced[SYNC_STB];
  assign blank_s = synced[SYNC_BLANK];

  sld_shift_latch #(.W(W)) core_i (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .dat_s(dat_s), .stb_s(stb_s),
    .shift_q(shift_q), .latch_q(latch_q)
  );

  sld_timing_mon #(
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .CLKW_CYC(CLKW_CYC),
    .C2S_CYC(C2S_CYC), .STBW_CYC(STBW_CYC)
  ) mon_i (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .dat_s(dat_s), .stb_s(stb_s),
    .clr(viol_clr), .flags(viol_flags)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_drv
      assign drive_out[i] = latch_q[i] & ~blank_s;
    end
  endgenerate

  assign ser_out = shift_q[W-1];
endmodule

// File: rtl/sld_checker.sv
module sld_checker
  import sld_pkg::*;
#(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                blank_in,
  input logic                viol_clr,
  input logic [NUM_VIOL-1:0] viol_flags,
  input logic [W-1:0]        drive_out,
  input logic                ser_out,
  input logic                sclk_s,
  input logic                dat_s,
  input logic                stb_s,
  input logic [W-1:0]        shift_q,
  input logic [W-1:0]        latch_q
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk) begin
    if (rst) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  // R1: a synchronized clock rise shifts data into stage 1
  assert_shift_step_R1: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd3 && $rose(sclk_s)) |=>
      shift_q == {$past(shift_q[W-2:0]), $past(dat_s)});

  // R2: serial output shows the former stage 7 after a shift
  assert_ser_chain_R2: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd3 && $rose(sclk_s)) |=> ser_out == $past(shift_q[W-2]));

  // R4: latch holds while strobe is low
  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd3 && !stb_s) |=> $stable(latch_q));

  // R5: outputs off two cycles after a high blanking input
  assert_blank_off_R5: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd3 && $past(blank_in, 2)) |-> drive_out == '0);

  // R12: without clear, a set flag never drops
  assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd3 && !viol_clr) |=>
      ((viol_flags & $past(viol_flags)) == $past(viol_flags)));
endmodule

bind shift_latch_driver sld_checker #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .blank_in(blank_in), .viol_clr(viol_clr),
  .viol_flags(viol_flags), .drive_out(drive_out), .ser_out(ser_out),
  .sclk_s(sclk_s), .dat_s(dat_s), .stb_s(stb_s),
  .shift_q(shift_q), .latch_q(latch_q)
);

// File: tb/shift_latch_driver_tb_top.sv
module shift_latch_driver_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       sclk_in, sdata_in, strobe_in, blank_in, viol_clr;
  logic       ser_out;
  logic [7:0] drive_out;
  logic [4:0] viol_flags;

  int total = 0;
  int bad   = 0;
  logic [7:0] m_sh, m_lat;
  logic       stb_lvl, blank_lvl;

  always #4 clk = ~clk;

  shift_latch_driver dut_i (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .strobe_in(strobe_in), .blank_in(blank_in), .viol_clr(viol_clr),
    .ser_out(ser_out), .drive_out(drive_out), .viol_flags(viol_flags)
  );

  function automatic logic [7:0] exp_out();
    return blank_lvl ? 8'h00 : m_lat;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_step(input logic b);
    m_sh = {m_sh[6:0], b};
    if (stb_lvl) m_lat = m_sh;
  endtask

  // Legal bit: setup 20, high 25, low 5 cycles
  task automatic shift_bit(input logic b);
    sdata_in = b;
    cyc(20);
    sclk_in = 1'b1;
    model_step(b);
    cyc(25);
    sclk_in = 1'b0;
    cyc(5);
  endtask

  task automatic strobe_pulse(input int n);
    strobe_in = 1'b1;
    stb_lvl   = 1'b1;
    m_lat     = m_sh;
    cyc(n);
    strobe_in = 1'b0;
    stb_lvl   = 1'b0;
    cyc(6);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(4);
    rst = 1'b0;
    m_sh  = '0;
    m_lat = '0;
    cyc(3);
  endtask

  task automatic viol_expect(input string req, input int idx);
    cyc(8);
    chk(req, 32'(viol_flags), 32'(1) << idx);
    cyc(20);
    chk("R12 sticky", 32'(viol_flags), 32'(1) << idx);
    viol_clr = 1'b1;
    cyc(1);
    viol_clr = 1'b0;
    cyc(2);
    chk("R12 clear", 32'(viol_flags), 32'd0);
  endtask

  initial begin
    logic [7:0] saved;
    logic [7:0] word;
    logic       b;
    void'($urandom(32'd20240611));
    sclk_in = 0; sdata_in = 0; strobe_in = 0; blank_in = 0; viol_clr = 0;
    stb_lvl = 0; blank_lvl = 0; m_sh = '0; m_lat = '0;
    do_reset();
    chk("R13 drive", 32'(drive_out), 32'd0);
    chk("R13 ser", 32'(ser_out), 32'd0);
    chk("R13 flags", 32'(viol_flags), 32'd0);

    // Strobe held high: latch bypassed
    strobe_in = 1'b1; stb_lvl = 1'b1; m_lat = m_sh;
    cyc(10);
    for (int i = 0; i < 8; i++) begin
      b = 1'($urandom % 2);
      shift_bit(b);
      chk("R1", 32'(drive_out[0]), 32'(b));
      chk("R3", 32'(drive_out), 32'(exp_out()));
      chk("R2", 32'(ser_out), 32'(m_sh[7]));
    end
    strobe_in = 1'b0; stb_lvl = 1'b0;
    cyc(10);

    // Strobe low: outputs frozen while loading
    saved = m_lat;
    word = ~m_sh;
    for (int i = 7; i >= 0; i--) begin
      shift_bit(word[i]);
      chk("R4", 32'(drive_out), 32'(saved));
      chk("R2", 32'(ser_out), 32'(m_sh[7]));
    end
    chk("R1 word", 32'(m_sh), 32'(word));
    cyc(15);
    strobe_pulse(20);
    chk("R3 pulse", 32'(drive_out), 32'(word));
    chk("R7 legal", 32'(viol_flags), 32'd0);

    // Reset with data held
    do_reset();
    chk("R13 drive", 32'(drive_out), 32'd0);
    chk("R13 ser", 32'(ser_out), 32'd0);

    // Blanking
    word = 8'hA7;
    for (int i = 7; i >= 0; i--) shift_bit(word[i]);
    cyc(15);
    strobe_pulse(20);
    chk("R3", 32'(drive_out), 32'(word));
    blank_in = 1'b1; blank_lvl = 1'b1;
    cyc(5);
    chk("R5", 32'(drive_out), 32'd0);
    cyc(10);
    blank_in = 1'b0; blank_lvl = 1'b0;
    cyc(5);
    chk("R6 restore", 32'(drive_out), 32'(word));
    chk("R6 ser", 32'(ser_out), 32'(word[7]));
    blank_in = 1'b1; blank_lvl = 1'b1;
    word = 8'h3C;
    for (int i = 7; i >= 0; i--) begin
      shift_bit(word[i]);
      chk("R5 load", 32'(drive_out), 32'd0);
    end
    cyc(15);
    strobe_pulse(20);
    chk("R5 strobe", 32'(drive_out), 32'd0);
    blank_in = 1'b0; blank_lvl = 1'b0;
    cyc(5);
    chk("R6 new", 32'(drive_out), 32'(word));
    chk("R6 ser", 32'(ser_out), 32'(m_sh[7]));

    // Random words with random blanking
    for (int r = 0; r < 6; r++) begin
      word = 8'($urandom);
      blank_lvl = 1'($urandom % 2);
      blank_in = blank_lvl;
      for (int i = 7; i >= 0; i--) shift_bit(word[i]);
      cyc(15);
      strobe_pulse(20);
      chk("R3 rand", 32'(drive_out), 32'(exp_out()));
      chk("R2 rand", 32'(ser_out), 32'(word[7]));
      chk("R9 legal", 32'(viol_flags), 32'd0);
    end
    blank_in = 1'b0; blank_lvl = 1'b0;
    cyc(50);

    // R7 setup: data changes 2 cycles before clock rise
    b = ~sdata_in;
    sdata_in = b;
    cyc(2);
    sclk_in = 1'b1; model_step(b);
    cyc(25);
    sclk_in = 1'b0;
    cyc(30);
    viol_expect("R7", 0);

    // R8 hold: data changes 3 cycles after clock rise
    cyc(30);
    b = sdata_in;
    sclk_in = 1'b1; model_step(b);
    cyc(3);
    sdata_in = ~b;
    cyc(22);
    sclk_in = 1'b0;
    cyc(30);
    viol_expect("R8", 1);

    // R9 clock width: 5-cycle high phase
    cyc(50);
    sclk_in = 1'b1; model_step(sdata_in);
    cyc(5);
    sclk_in = 1'b0;
    cyc(40);
    viol_expect("R9", 2);

    // R10 strobe rises about 30 cycles after clock rise
    cyc(50);
    shift_bit(1'b1);
    strobe_pulse(20);
    chk("R3 c2s", 32'(drive_out), 32'(m_sh));
    viol_expect("R10", 3);

    // R11 strobe high only 3 cycles
    cyc(60);
    strobe_pulse(3);
    viol_expect("R11", 4);
    chk("R2 end", 32'(ser_out), 32'(m_sh[7]));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule